// File: doc/BRIEF.md
# Packed-BCD Accumulator with Readable Decimal Correction

This block is an 8-bit accumulator datapath that holds two flags: a carry/borrow flag (CY) out of bit 7 and a half-carry/half-borrow flag (AC) out of bit 3. It does not have a dedicated decimal-adjust operation. Instead, a read-only correction value is derived combinationally from the accumulator, the two flags and a remembered mode bit. The mode bit records whether the latest arithmetic operation was an add or a subtract. Software-style sequencing then applies that value with an ordinary binary operation.

A packed-BCD subtraction takes three strobes. The first loads the minuend. The second subtracts the subtrahend in binary. The third subtracts the correction value in binary. The accumulator then holds the two decimal digits and CY holds the decimal borrow. Addition uses the same pattern with binary adds. Every operation is a single-cycle strobe with a 3-bit opcode and an 8-bit operand. The accumulator, flags and correction value are always visible on the outputs.

Top module: `bcd_adjust_alu`

## Requirements
- R1: While reset is high, and on the first cycle after it, the accumulator is 00h, CY and AC are 0, the mode is subtract, and the correction output reads 00h.
- R2: Opcode 0 (load) with the strobe high writes the operand into the accumulator on the next clock edge. CY, AC and the mode keep their values.
- R3: Opcode 2 (binary subtract) sets the accumulator to (acc - operand) mod 256. CY is set on a borrow out of bit 7 and AC on a borrow out of bit 3. The mode becomes subtract.
- R4: Opcode 1 (binary add) sets the accumulator to (acc + operand) mod 256. CY is set on a carry out of bit 7 and AC on a carry out of bit 3. The mode becomes add.
- R5: In subtract mode, the correction output includes 06h when AC=1 or bits 3:0 exceed 9. It includes 60h when CY=1 or bits 7:4 exceed 9.
- R6: In add mode, the correction output includes 06h when AC=1 or bits 3:0 exceed 9. It includes 60h when CY=1 or the accumulator exceeds 99h.
- R7: The correction rules follow the latest add or subtract (including opcodes 3 and 4). A load does not change which rule set applies.
- R8: Opcode 3 subtracts the current correction value in binary. The new CY is the old CY ORed with the borrow out of bit 7. AC is the borrow out of bit 3. The mode becomes subtract.
- R9: Opcode 4 adds the current correction value in binary. The new CY is the old CY ORed with the carry out of bit 7. AC is the carry out of bit 3. The mode becomes add.
- R10: Opcode 5 (write to the correction register), opcodes 6 and 7, and any cycle with the strobe low leave the accumulator, flags, mode and correction output unchanged.
- R11: Loading 91h and subtracting 52h gives accumulator 3Fh with CY=0, AC=1 and correction 06h. Applying opcode 3 next gives 39h with CY=0 and AC=0.
- R12: For all two-digit BCD operands a and b, the sequences load a / subtract b / opcode 3 and load a / add b / opcode 4 produce the decimal result. CY ends as the decimal borrow (a < b) or carry (a + b >= 100).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 3 | 0 load, 1 add, 2 sub, 3 sub correction, 4 add correction, 5 correction write (ignored), 6-7 no operation |
| op_data | input | 8 | Operand |
| acc_q | output | 8 | Accumulator |
| cy_q | output | 1 | Carry/borrow flag |
| ac_q | output | 1 | Half-carry/half-borrow flag |
| adj_q | output | 8 | Correction value derived from the current state |

## Verification
The accumulator, CY and AC are each one register stage from the strobe, so they change on the clock edge that samples the strobe. The correction output is combinational from those registers and settles in the same cycle. The bench drives each strobe on a falling edge and samples all four outputs on the next falling edge, half a period after the capturing edge. Checks therefore never land on the edge itself. Idle and ignored opcodes are checked at that same falling edge against the unchanged model state.

// File: rtl/bcd_alu_pkg.sv
`timescale 1ns/1ps
package bcd_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = DATA_W / NIB_W;
    localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] NIB_FIX   = NIB_W'(6);

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_ADD     = 3'd1,
        OP_SUB     = 3'd2,
        OP_SUB_ADJ = 3'd3,
        OP_ADD_ADJ = 3'd4,
        OP_WR_ADJ  = 3'd5,
        OP_NOP6    = 3'd6,
        OP_NOP7    = 3'd7
    } op_e;

    typedef struct packed {
        logic cy;
        logic ac;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        flags_t            fl;
    } alu_res_t;

    typedef struct packed {
        logic wr_acc;
        logic wr_flags;
        logic wr_mode;
        logic mode_add;
        logic do_sub;
        logic use_adj;
        logic sticky_cy;
    } ctrl_t;

    function automatic ctrl_t decode_op(input logic valid, input op_e op);
        ctrl_t c;
        c = '0;
        if (valid) begin
            unique case (op)
                OP_LOAD: begin
                    c.wr_acc = 1'b1;
                end
                OP_ADD: begin
                    c.wr_acc   = 1'b1;
                    c.wr_flags = 1'b1;
                    c.wr_mode  = 1'b1;
                    c.mode_add = 1'b1;
                end
                OP_SUB: begin
                    c.wr_acc   = 1'b1;
                    c.wr_flags = 1'b1;
                    c.wr_mode  = 1'b1;
                    c.do_sub   = 1'b1;
                end
                OP_SUB_ADJ: begin
                    c.wr_acc    = 1'b1;
                    c.wr_flags  = 1'b1;
                    c.wr_mode   = 1'b1;
                    c.do_sub    = 1'b1;
                    c.use_adj   = 1'b1;
                    c.sticky_cy = 1'b1;
                end
                OP_ADD_ADJ: begin
                    c.wr_acc    = 1'b1;
                    c.wr_flags  = 1'b1;
                    c.wr_mode   = 1'b1;
                    c.mode_add  = 1'b1;
                    c.use_adj   = 1'b1;
                    c.sticky_cy = 1'b1;
                end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/bcd_arith_unit.sv
`timescale 1ns/1ps
module bcd_arith_unit
    import bcd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              do_sub,
    input  logic              sticky_cy,
    input  flags_t            old_fl,
    output alu_res_t          res
);

    logic [NIB_CNT:0]    chain;
    logic [DATA_W-1:0]   sum;
    logic [DATA_W-1:0]   b_eff;

    assign b_eff    = b_in ^ {DATA_W{do_sub}};
    assign chain[0] = do_sub;

    for (genvar i = 0; i < NIB_CNT; i++) begin : g_nib
        logic [NIB_W:0] part;
        assign part = {1'b0, a_in[i*NIB_W +: NIB_W]}
                    + {1'b0, b_eff[i*NIB_W +: NIB_W]}
                    + {{NIB_W{1'b0}}, chain[i]};
        assign sum[i*NIB_W +: NIB_W] = part[NIB_W-1:0];
        assign chain[i+1]            = part[NIB_W];
    end

    logic raw_cy;
    logic raw_ac;

    // a carry of 1 in subtract mode means no borrow
    assign raw_cy = chain[NIB_CNT] ^ do_sub;
    assign raw_ac = chain[1] ^ do_sub;

    always_comb begin
        res.val   = sum;
        res.fl.cy = raw_cy | (sticky_cy & old_fl.cy);
        res.fl.ac = raw_ac;
    end

endmodule

// File: rtl/bcd_adj_unit.sv
`timescale 1ns/1ps
module bcd_adj_unit
    import bcd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  flags_t            fl,
    input  logic              mode_add,
    output logic [DATA_W-1:0] adj
);

    logic [NIB_CNT-1:0] over9;
    logic [NIB_CNT-1:0] need;

    for (genvar i = 0; i < NIB_CNT; i++) begin : g_dig
        logic [NIB_W-1:0] dig;
        logic             flag_in;
        assign dig      = acc[i*NIB_W +: NIB_W];
        assign over9[i] = dig > DIGIT_MAX;

        if (i == 0) begin : g_low
            assign flag_in = fl.ac;
            assign need[i] = flag_in | over9[i];
        end else begin : g_high
            assign flag_in = (i == NIB_CNT-1) ? fl.cy : 1'b0;
            // in add mode a 9 here overflows once the lower digit is fixed
            assign need[i] = flag_in | over9[i]
                           | (mode_add & (dig == DIGIT_MAX) & over9[i-1]);
        end

        assign adj[i*NIB_W +: NIB_W] = need[i] ? NIB_FIX : '0;
    end

endmodule

// File: rtl/bcd_state_regs.sv
`timescale 1ns/1ps
module bcd_state_regs
    import bcd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  alu_res_t          alu_res,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] acc,
    output flags_t            fl,
    output logic              mode_add
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            fl       <= '0;
            mode_add <= 1'b0;
        end else begin
            if (ctrl.wr_acc) begin
                acc <= ctrl.wr_flags ? alu_res.val : load_val;
            end
            if (ctrl.wr_flags) begin
                fl <= alu_res.fl;
            end
            if (ctrl.wr_mode) begin
                mode_add <= ctrl.mode_add;
            end
        end
    end

endmodule

// File: rtl/bcd_adjust_alu.sv
`timescale 1ns/1ps
module bcd_adjust_alu
    import bcd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] op_data,
    output logic [DATA_W-1:0] acc_q,
    output logic              cy_q,
    output logic              ac_q,
    output logic [DATA_W-1:0] adj_q
);

    ctrl_t             ctrl;
    alu_res_t          alu_res;
    flags_t            fl;
    logic              mode_add;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] adj;
    logic [DATA_W-1:0] operand;

    assign ctrl    = decode_op(op_valid, op_e'(op_code));
    assign operand = ctrl.use_adj ? adj : op_data;

    bcd_adj_unit u_adj (
        .acc      (acc),
        .fl       (fl),
        .mode_add (mode_add),
        .adj      (adj)
    );

    bcd_arith_unit u_arith (
        .a_in      (acc),
        .b_in      (operand),
        .do_sub    (ctrl.do_sub),
        .sticky_cy (ctrl.sticky_cy),
        .old_fl    (fl),
        .res       (alu_res)
    );

    bcd_state_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .alu_res  (alu_res),
        .load_val (op_data),
        .acc      (acc),
        .fl       (fl),
        .mode_add (mode_add)
    );

    assign acc_q = acc;
    assign cy_q  = fl.cy;
    assign ac_q  = fl.ac;
    assign adj_q = adj;

endmodule

// File: rtl/bcd_adjust_alu_chk.sv
`timescale 1ns/1ps
module bcd_adjust_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [7:0] op_data,
    input logic [7:0] acc_q,
    input logic       cy_q,
    input logic       ac_q,
    input logic [7:0] adj_q
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_q == 8'h00 && !cy_q && !ac_q && adj_q == 8'h00));

    a_r2_load_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0) |=>
            (acc_q == $past(op_data) && cy_q == $past(cy_q) && ac_q == $past(ac_q)));

    a_r3_sub_borrow: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2) |=>
            (cy_q == ($past(acc_q) < $past(op_data))));

    a_r4_add_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1) |=>
            (cy_q == ({1'b0, $past(acc_q)} + {1'b0, $past(op_data)} > 9'd255)));

    // R5, R6: the correction can only take four values
    a_r5_adj_codes: assert property (@(posedge clk) disable iff (rst)
        (adj_q == 8'h00 || adj_q == 8'h06 || adj_q == 8'h60 || adj_q == 8'h66));

    a_r8_sticky_borrow: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd3 && cy_q) |=> cy_q);

    a_r9_sticky_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4 && cy_q) |=> cy_q);

    a_r10_no_effect: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code >= 3'd5) |=>
            ($stable(acc_q) && $stable(cy_q) && $stable(ac_q) && $stable(adj_q)));

endmodule

bind bcd_adjust_alu bcd_adjust_alu_chk u_chk (.*);

// File: tb/sim_bcd_adjust_alu.sv
`timescale 1ns/1ps
module sim_bcd_adjust_alu;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [2:0] op_code;
    logic [7:0] op_data;
    logic [7:0] acc_q;
    logic       cy_q;
    logic       ac_q;
    logic [7:0] adj_q;

    always #4 clk = ~clk;

    bcd_adjust_alu u0 (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_data  (op_data),
        .acc_q    (acc_q),
        .cy_q     (cy_q),
        .ac_q     (ac_q),
        .adj_q    (adj_q)
    );

    int n_vec = 0;
    int n_bad = 0;

    int m_acc = 0;
    bit m_cy  = 0;
    bit m_ac  = 0;
    bit m_add = 0;

    function automatic int ref_corr();
        int lo;
        int hi;
        int c;
        lo = m_acc % 16;
        hi = m_acc / 16;
        c  = 0;
        if (m_ac || lo > 9) c += 6;
        if (m_add) begin
            if (m_cy || m_acc > 'h99) c += 'h60;
        end else begin
            if (m_cy || hi > 9) c += 'h60;
        end
        return c;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R2";
            1: return "R4";
            2: return "R3";
            3: return "R8";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step(int op, int d);
        int c;
        c = ref_corr();
        case (op)
            0: m_acc = d;
            1: begin
                m_cy  = (m_acc + d) > 255;
                m_ac  = (m_acc % 16 + d % 16) > 15;
                m_acc = (m_acc + d) % 256;
                m_add = 1;
            end
            2: begin
                m_cy  = m_acc < d;
                m_ac  = (m_acc % 16) < (d % 16);
                m_acc = (m_acc - d + 256) % 256;
                m_add = 0;
            end
            3: begin
                m_cy  = m_cy | (m_acc < c);
                m_ac  = (m_acc % 16) < (c % 16);
                m_acc = (m_acc - c + 256) % 256;
                m_add = 0;
            end
            4: begin
                m_cy  = m_cy | ((m_acc + c) > 255);
                m_ac  = (m_acc % 16 + c % 16) > 15;
                m_acc = (m_acc + c) % 256;
                m_add = 1;
            end
            default: ;
        endcase
    endtask

    task automatic check_state(string req);
        chk({req, " acc"}, acc_q, m_acc);
        chk({req, " cy"}, cy_q, m_cy);
        chk({req, " ac"}, ac_q, m_ac);
        chk({req, " adj"}, adj_q, ref_corr());
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(int op, int d, bit full);
        op_valid = 1'b1;
        op_code  = op[2:0];
        op_data  = d[7:0];
        @(negedge clk);
        op_valid = 1'b0;
        model_step(op, d);
        if (full) check_state(req_of(op));
    endtask

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + v % 10;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int junk;
        junk     = $urandom(32'h0BCD_5EED);
        rst      = 1'b1;
        op_valid = 1'b0;
        op_code  = 3'd0;
        op_data  = 8'h00;
        repeat (3) @(negedge clk);
        // R1: state while reset is high
        chk("R1 acc", acc_q, 0);
        chk("R1 adj", adj_q, 0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");

        // R11 worked example
        apply(0, 'h91, 1);
        apply(2, 'h52, 1);
        chk("R11 acc", acc_q, 'h3F);
        chk("R11 cy", cy_q, 0);
        chk("R11 ac", ac_q, 1);
        chk("R11 adj", adj_q, 'h06);
        apply(3, 0, 1);
        chk("R11 final acc", acc_q, 'h39);
        chk("R11 final cy", cy_q, 0);
        chk("R11 final ac", ac_q, 0);

        // R6: 45 + 55 needs both digit fixes and ends in a carry
        apply(0, 'h45, 1);
        apply(1, 'h55, 1);
        chk("R6 adj", adj_q, 'h66);
        apply(4, 0, 1);
        chk("R9 acc", acc_q, 'h00);
        chk("R9 cy", cy_q, 1);

        // R7: a load keeps add rules; 9Ah reads 66h in add mode, 06h in sub mode
        apply(0, 'h9A, 1);
        chk("R7 add mode adj", adj_q, 'h66);
        apply(2, 'h00, 1);
        chk("R7 sub mode adj", adj_q, 'h06);

        // R5: borrow out of bit 7 forces the high fix
        apply(0, 'h10, 1);
        apply(2, 'h20, 1);
        chk("R5 adj", adj_q, 'h66 & 'h60);
        apply(3, 0, 1);
        chk("R8 acc", acc_q, 'h90);
        chk("R8 cy", cy_q, 1);

        // R10: correction write and spare codes are ignored
        apply(0, 'h5C, 1);
        apply(5, 'h77, 1);
        apply(6, 'h12, 1);
        apply(7, 'hFF, 1);
        chk("R10 acc", acc_q, 'h5C);
        for (int k = 0; k < 4; k++) begin
            op_code = k[2:0];
            op_data = 8'hA5;
            @(negedge clk);
            check_state("R10 idle");
        end

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            int op;
            int d;
            op = int'($urandom_range(0, 7));
            d  = int'($urandom_range(0, 255));
            if (k % 5 == 0) d = to_bcd(int'($urandom_range(0, 99)));
            apply(op, d, 1);
        end

        // R12: full two-digit decimal sweep
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                apply(0, to_bcd(a), 0);
                apply(2, to_bcd(b), 0);
                apply(3, 0, 0);
                chk("R12 sub acc", acc_q, to_bcd((a - b + 100) % 100));
                chk("R12 sub cy", cy_q, (a < b) ? 1 : 0);
                apply(0, to_bcd(a), 0);
                apply(1, to_bcd(b), 0);
                apply(4, 0, 0);
                chk("R12 add acc", acc_q, to_bcd((a + b) % 100));
                chk("R12 add cy", cy_q, (a + b >= 100) ? 1 : 0);
            end
        end

        summary();
        $finish;
    end

endmodule